// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Sequencer

This block keeps the program counter of a small processor and returns the instruction word stored at that address. Program space is addressed in bytes through a 21-bit counter, so it spans 2 MB. Instructions are 16-bit words. Only the bottom part of that space holds physical program memory. A fetch above the implemented part reads as all zeros, which the decoder treats as a no-operation, and it never aliases back onto low memory.

Each cycle the counter takes exactly one of these actions: return to the reset vector, enter one of two interrupt vectors, load a jump target, step to the next word, or hold. Four separate reset sources can force a return to the reset vector: an external clear pin, power-up, watchdog overflow and brown-out. They act in addition to the synchronous block reset. The program memory is an internal array whose contents the testbench loads. Execution, the return stack and interrupt enabling belong to other blocks.

Top module: `fetch_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pc_o` becomes 0x000000, and `instr_o` then shows the word at address 0.
- R2: If any bit of `rst_src_i` is high at an edge (bit 0 external clear pin, bit 1 power-up, bit 2 watchdog overflow, bit 3 brown-out), `pc_o` becomes 0x000000. This takes priority over every other request.
- R3: `adv_i` alone steps `pc_o` by 2 at the next edge, and the step wraps modulo 2^21 (0x1FFFFE steps to 0x000000).
- R4: When no request is present, `pc_o` keeps its value.
- R5: `jmp_i` loads `jmp_tgt_i` with bit 0 forced to zero. A jump takes priority over `adv_i`.
- R6: `irq_hi_i` loads 0x000008. It takes priority over `irq_lo_i`, `jmp_i` and `adv_i`.
- R7: `irq_lo_i` without `irq_hi_i` loads 0x000018. It takes priority over `jmp_i` and `adv_i`.
- R8: When `pc_o` is below `IMPL_BYTES`, `instr_o` shows in the same cycle the word held at index `pc_o >> 1`.
- R9: When `pc_o` is at or above `IMPL_BYTES`, `instr_o` is 0x0000.
- R10: `pc_o` is always even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| rst_src_i | input | 4 | Reset sources, active high: clear pin, power-up, watchdog, brown-out |
| adv_i | input | 1 | Step to the next sequential word |
| jmp_i | input | 1 | Load the jump target |
| jmp_tgt_i | input | 21 | Jump byte address; bit 0 is ignored |
| irq_hi_i | input | 1 | High-priority interrupt entry request |
| irq_lo_i | input | 1 | Low-priority interrupt entry request |
| pc_o | output | 21 | Program counter (byte address) |
| instr_o | output | 16 | Instruction word at `pc_o` |

## Verification
A wrong counter value appears on `pc_o` at the first edge after the faulty request, and in that same cycle `instr_o` shows a word from the wrong place. A wrong choice between simultaneous requests shows up in the same way, one edge later, as the wrong vector or target. Reads past the implemented range are checked at the last implemented word, at the first missing word, and in the far upper half of the space. This would expose aliasing or an off-by-one boundary as a nonzero word right away.

// File: rtl/fetch_pkg.sv
// Shared types for the fetch sequencer.
// Assumes: a single clock domain; vectors are byte addresses.
package fetch_pkg;

    // Which source selected the next program counter value
    typedef enum logic [2:0] {
        SEL_HOLD   = 3'd0,
        SEL_SEQ    = 3'd1,
        SEL_JUMP   = 3'd2,
        SEL_IRQ_LO = 3'd3,
        SEL_IRQ_HI = 3'd4,
        SEL_RESET  = 3'd5
    } pc_sel_e;

endpackage

// File: rtl/fetch_reset_merge.sv
// Folds several active-high reset sources into one request.
// Assumes: every source is already synchronous to clk.
module fetch_reset_merge #(
    parameter int N_SRC = 4
) (
    input  logic [N_SRC-1:0] src_i,
    output logic             req_o
);

    logic [N_SRC:0] chain;

    assign chain[0] = 1'b0;

    // OR chain, one stage per source
    for (genvar g = 0; g < N_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | src_i[g];
    end

    assign req_o = chain[N_SRC];

endmodule

// File: rtl/fetch_next_pc.sv
// Chooses the next program counter value by fixed priority:
// reset source, high interrupt, low interrupt, jump, sequential step, hold.
// Assumes: pc_i is even; bit 0 of the target is dropped.
module fetch_next_pc
    import fetch_pkg::*;
#(
    parameter int          PC_W      = 21,
    parameter logic [20:0] RESET_VEC = 21'h000000,
    parameter logic [20:0] HI_VEC    = 21'h000008,
    parameter logic [20:0] LO_VEC    = 21'h000018
) (
    input  logic [PC_W-1:0] pc_i,
    input  logic            rst_req_i,
    input  logic            adv_i,
    input  logic            jmp_i,
    input  logic [PC_W-1:0] tgt_i,
    input  logic            irq_hi_i,
    input  logic            irq_lo_i,
    output logic [PC_W-1:0] nxt_o,
    output pc_sel_e         sel_o
);

    localparam logic [PC_W-1:0] STEP     = PC_W'(2);
    localparam logic [PC_W-1:0] EVEN_MSK = ~PC_W'(1);

    // Priority selection of the update source
    always_comb begin
        if (rst_req_i)     sel_o = SEL_RESET;
        else if (irq_hi_i) sel_o = SEL_IRQ_HI;
        else if (irq_lo_i) sel_o = SEL_IRQ_LO;
        else if (jmp_i)    sel_o = SEL_JUMP;
        else if (adv_i)    sel_o = SEL_SEQ;
        else               sel_o = SEL_HOLD;
    end

    // Next address for the chosen source
    always_comb begin
        unique case (sel_o)
            SEL_RESET:  nxt_o = PC_W'(RESET_VEC);
            SEL_IRQ_HI: nxt_o = PC_W'(HI_VEC);
            SEL_IRQ_LO: nxt_o = PC_W'(LO_VEC);
            SEL_JUMP:   nxt_o = tgt_i & EVEN_MSK;
            SEL_SEQ:    nxt_o = pc_i + STEP;
            default:    nxt_o = pc_i;
        endcase
    end

endmodule

// File: rtl/fetch_prog_rom.sv
// Program word store with asynchronous read.
// Addresses at or beyond IMPL_BYTES read as zero rather than aliasing.
// Assumes: IMPL_BYTES is a power of two; contents are loaded by the environment.
module fetch_prog_rom #(
    parameter int PC_W       = 21,
    parameter int INSTR_W    = 16,
    parameter int IMPL_BYTES = 4096
) (
    input  logic [PC_W-1:0]    addr_i,
    output logic [INSTR_W-1:0] word_o
);

    localparam int WORDS = IMPL_BYTES / 2;
    localparam int IDX_W = $clog2(WORDS);

    logic [INSTR_W-1:0] mem [WORDS];
    logic               in_range;

    // Blank store until the environment loads a program
    initial begin
        for (int i = 0; i < WORDS; i++) mem[i] = '0;
    end

    // Range test against the implemented size
    assign in_range = addr_i < PC_W'(IMPL_BYTES);

    // Word read, zero outside the implemented range
    assign word_o = in_range ? mem[addr_i[IDX_W:1]] : '0;

endmodule

// File: rtl/fetch_unit.sv
// Top of the fetch sequencer: the program counter register, next-address
// selection, reset-source merge and program store.
// Assumes: synchronous active-low rst_n; all requests sampled at posedge clk.
module fetch_unit #(
    parameter int PC_W       = 21,
    parameter int INSTR_W    = 16,
    parameter int IMPL_BYTES = 4096,
    parameter int N_RST      = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_RST-1:0]   rst_src_i,
    input  logic               adv_i,
    input  logic               jmp_i,
    input  logic [PC_W-1:0]    jmp_tgt_i,
    input  logic               irq_hi_i,
    input  logic               irq_lo_i,
    output logic [PC_W-1:0]    pc_o,
    output logic [INSTR_W-1:0] instr_o
);

    import fetch_pkg::*;

    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_nxt;
    logic            rst_req;
    pc_sel_e         sel;

    fetch_reset_merge #(.N_SRC(N_RST)) u_rst (
        .src_i (rst_src_i),
        .req_o (rst_req)
    );

    fetch_next_pc #(.PC_W(PC_W)) u_nxt (
        .pc_i      (pc_q),
        .rst_req_i (rst_req),
        .adv_i     (adv_i),
        .jmp_i     (jmp_i),
        .tgt_i     (jmp_tgt_i),
        .irq_hi_i  (irq_hi_i),
        .irq_lo_i  (irq_lo_i),
        .nxt_o     (pc_nxt),
        .sel_o     (sel)
    );

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    fetch_prog_rom #(
        .PC_W       (PC_W),
        .INSTR_W    (INSTR_W),
        .IMPL_BYTES (IMPL_BYTES)
    ) u_rom (
        .addr_i (pc_q),
        .word_o (instr_o)
    );

    assign pc_o = pc_q;

endmodule

// File: rtl/fetch_unit_chk.sv
// Port-level properties of the fetch sequencer, bound to every fetch_unit.
// Assumes: default vector addresses 0x000000, 0x000008 and 0x000018.
module fetch_unit_chk #(
    parameter int PC_W       = 21,
    parameter int INSTR_W    = 16,
    parameter int IMPL_BYTES = 4096,
    parameter int N_RST      = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_RST-1:0]   rst_src_i,
    input logic               adv_i,
    input logic               jmp_i,
    input logic [PC_W-1:0]    jmp_tgt_i,
    input logic               irq_hi_i,
    input logic               irq_lo_i,
    input logic [PC_W-1:0]    pc_o,
    input logic [INSTR_W-1:0] instr_o
);

    // R2
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rst_src_i) |=> pc_o == '0);

    // R3
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rst_src_i) && !irq_hi_i && !irq_lo_i && !jmp_i && adv_i)
        |=> pc_o == $past(pc_o) + PC_W'(2));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rst_src_i) && !irq_hi_i && !irq_lo_i && !jmp_i && !adv_i)
        |=> $stable(pc_o));

    // R5
    jump_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rst_src_i) && !irq_hi_i && !irq_lo_i && jmp_i)
        |=> pc_o == {$past(jmp_tgt_i[PC_W-1:1]), 1'b0});

    // R6
    irq_hi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rst_src_i) && irq_hi_i) |=> pc_o == PC_W'(8));

    // R7
    irq_lo_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|rst_src_i) && !irq_hi_i && irq_lo_i) |=> pc_o == PC_W'(24));

    // R9
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o >= PC_W'(IMPL_BYTES)) |-> instr_o == '0);

    // R10
    pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[0] == 1'b0);

endmodule

bind fetch_unit fetch_unit_chk #(
    .PC_W       (PC_W),
    .INSTR_W    (INSTR_W),
    .IMPL_BYTES (IMPL_BYTES),
    .N_RST      (N_RST)
) u_chk (.*);

// File: tb/tb_fetch_unit.sv
// Directed bench for fetch_unit: one task for each scenario.
module tb_fetch_unit;

    localparam int PC_W  = 21;
    localparam int IMPL  = 4096;
    localparam int WORDS = IMPL / 2;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [3:0]       rst_src_i;
    logic             adv_i, jmp_i, irq_hi_i, irq_lo_i;
    logic [PC_W-1:0]  jmp_tgt_i;
    logic [PC_W-1:0]  pc_o;
    logic [15:0]      instr_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fetch_unit #(.IMPL_BYTES(IMPL)) dut (
        .clk, .rst_n, .rst_src_i, .adv_i, .jmp_i, .jmp_tgt_i,
        .irq_hi_i, .irq_lo_i, .pc_o, .instr_o
    );

    // Program pattern: never zero, so a zero read is visible
    function automatic logic [15:0] pat(int idx);
        return (16'(idx * 5) & 16'h7FFF) | 16'h8000;
    endfunction

    // Expected word at a byte address
    function automatic logic [15:0] exp_word(logic [PC_W-1:0] a);
        if (a < PC_W'(IMPL)) return pat(int'(a >> 1));
        return 16'h0000;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        rst_src_i = '0; adv_i = 0; jmp_i = 0; irq_hi_i = 0; irq_lo_i = 0;
        jmp_tgt_i = '0;
    endtask

    // One edge with the current inputs, then sample at the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic jump_to(logic [PC_W-1:0] t);
        jmp_i = 1; jmp_tgt_i = t; tick();
    endtask

    task automatic t_reset();
        rst_n = 0; adv_i = 1; jmp_i = 1; jmp_tgt_i = 21'h100;
        tick(); tick();
        chk("R1 pc after reset", 32'(pc_o), 32'h0);
        chk("R1 word at 0", 32'(instr_o), 32'(pat(0)));
        rst_n = 1;
    endtask

    task automatic t_seq();
        for (int i = 1; i <= 5; i++) begin
            adv_i = 1; tick();
            chk("R3 step", 32'(pc_o), 32'(2 * i));
            chk("R8 word", 32'(instr_o), 32'(pat(i)));
        end
        tick();
        chk("R4 hold", 32'(pc_o), 32'd10);
    endtask

    task automatic t_jump();
        jmp_i = 1; adv_i = 1; jmp_tgt_i = 21'h000123; tick();
        chk("R5 odd target over advance", 32'(pc_o), 32'h122);
        chk("R10 even", 32'(pc_o[0]), 32'h0);
        chk("R8 word after jump", 32'(instr_o), 32'(exp_word(21'h122)));
    endtask

    task automatic t_irq();
        jump_to(21'h300);
        irq_hi_i = 1; irq_lo_i = 1; jmp_i = 1; jmp_tgt_i = 21'h200; adv_i = 1;
        tick();
        chk("R6 high wins", 32'(pc_o), 32'h8);
        chk("R8 word at 8", 32'(instr_o), 32'(pat(4)));
        irq_lo_i = 1; jmp_i = 1; jmp_tgt_i = 21'h200; adv_i = 1; tick();
        chk("R7 low over jump", 32'(pc_o), 32'h18);
    endtask

    task automatic t_rst_src();
        for (int b = 0; b < 4; b++) begin
            jump_to(21'h400);
            rst_src_i = 4'(1 << b); irq_hi_i = 1; jmp_i = 1;
            jmp_tgt_i = 21'h200; adv_i = 1;
            tick();
            chk($sformatf("R2 source bit %0d", b), 32'(pc_o), 32'h0);
        end
    endtask

    task automatic t_range();
        jump_to(21'(IMPL - 2));
        chk("R8 last implemented word", 32'(instr_o), 32'(pat(WORDS - 1)));
        adv_i = 1; tick();
        chk("R9 first missing word", 32'(instr_o), 32'h0);
        jump_to(21'h100000);
        chk("R9 upper space", 32'(instr_o), 32'h0);
        jump_to(21'h1FFFFE);
        chk("R9 top word", 32'(instr_o), 32'h0);
        adv_i = 1; tick();
        chk("R3 wrap", 32'(pc_o), 32'h0);
        chk("R8 word after wrap", 32'(instr_o), 32'(pat(0)));
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0;
        idle();
        #1;
        for (int i = 0; i < WORDS; i++) dut.u_rom.mem[i] = pat(i);
        @(negedge clk);
        t_reset();
        t_seq();
        t_jump();
        t_irq();
        t_rst_src();
        t_range();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule